// File: doc/BRIEF.md
# Victim Writeback Acceptance Controller

This block sits beside a small group of last-level cache lines and accepts victim writebacks that lower-level caches push up into them. A victim request names a line, the requestor, whether the victim is dirty and whether it was shared. When the request is taken, the controller acknowledges the requestor, remembers who must deliver the data and marks the line busy. While the line is busy its stable state is held unchanged. When the data message arrives, the line settles into a stable MOESI state. That state depends on the state held before, on the victim kind and on whether the data came back marked shared.

Each line has exactly one tracking entry. A second victim request to a busy line is stalled. A writeback cancel releases the entry, but only when it comes from the recorded sender. If the line is neither present nor has a free way, the controller first evicts the victim line that the replacement logic picked and leaves the request pending. An eviction aimed at a busy line is deferred. Every release of a busy line, by data or by cancel, produces one unblock toward the directory. A lookup port lets neighbouring logic read the state of any line.

Top module: `wbc_victim_ctrl`

## Requirements
- R1: After reset every line reads state I (code 0), not busy and not dirty, and every pulse output is low.
- R2: A victim request (req_cancel=0) to a line that is not busy, with req_room=1, is accepted. One cycle later ack_valid pulses with ack_id equal to req_id, and the line reads busy with its state unchanged.
- R3: A victim request to a busy line is stalled. One cycle later retry pulses, no ack is sent, and the line keeps its state and its recorded sender.
- R4: A victim request with req_room=0 is never accepted. If the line req_victim is not busy, repl_valid pulses one cycle later with repl_line=req_victim, that line becomes I and not dirty, and retry pulses. If req_victim is busy, only retry pulses.
- R5: Settling from base I or E (state codes I=0, S=1, E=2, O=3, M=4; shared means the victim shared flag or the data shared flag is set): a dirty victim goes to O if shared, otherwise to M. A clean victim goes to S if shared, otherwise to E.
- R6: Settling from base M goes to O if shared, otherwise to M. From base S or O, a shared case goes to O for S with a dirty victim, to S for S with a clean victim, and to O for O. A case from S or O that is not shared has no defined transition: proto_err pulses and the line stays busy in its base state.
- R7: Data for a busy line with a defined transition writes the line data, ORs dat_dirty into the dirty bit (never clearing it), clears busy, and pulses unblock_valid with unblock_line equal to the line, all one cycle later.
- R8: A cancel (req_cancel=1) to a busy line whose recorded sender equals req_id clears busy, leaves the base state in place (so a line allocated from I reads I again), and pulses unblock for that line one cycle later.
- R9: A cancel from a different requestor, or to a line that is not busy, is retried: retry pulses and there is no unblock.
- R10: When data completes a line in the same cycle as an otherwise valid cancel, the data wins the unblock and the cancel is retried.
- R11: Data for a line that is not busy raises proto_err one cycle later and changes no line.
- R12: Accepting a victim into a line whose state is not I pulses touch_valid with touch_line equal to the line one cycle later; accepting into an I line does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_cancel | input | 1 | 1 = writeback cancel, 0 = victim writeback |
| req_dirty | input | 1 | Victim carries dirty data |
| req_shared | input | 1 | Victim was held shared |
| req_line | input | LINE_W | Target line |
| req_id | input | ID_W | Requestor identifier |
| req_room | input | 1 | Line present or a free way exists |
| req_victim | input | LINE_W | Line chosen for replacement when there is no room |
| dat_valid | input | 1 | Writeback data present |
| dat_line | input | LINE_W | Line the data is for |
| dat_data | input | DATA_W | Writeback payload |
| dat_dirty | input | 1 | Payload is dirty |
| dat_shared | input | 1 | Payload returned marked shared |
| look_line | input | LINE_W | Line to read on the lookup port |
| look_state | output | 3 | Stable state of look_line (encoding in R5) |
| look_busy | output | 1 | look_line holds a tracking entry |
| look_dirty | output | 1 | Dirty bit of look_line |
| look_data | output | DATA_W | Data of look_line |
| ack_valid | output | 1 | Writeback acknowledge pulse |
| ack_id | output | ID_W | Requestor being acknowledged |
| unblock_valid | output | 1 | Unblock pulse toward the directory |
| unblock_line | output | LINE_W | Line being unblocked |
| repl_valid | output | 1 | Replacement eviction pulse |
| repl_line | output | LINE_W | Line evicted |
| touch_valid | output | 1 | Recency update pulse for a writeback hit |
| touch_line | output | LINE_W | Line to mark most recently used |
| retry | output | 1 | Last request was not consumed and must be presented again |
| proto_err | output | 1 | Data arrived with no defined transition |

## Verification
Completion of a line by data and release of another line by a matching cancel can both want the single unblock output in one cycle. The bench provokes this directly with a busy line receiving shared data while a different line is cancelled by its recorded sender. It also lets the random phase hit the case, with data and requests to four lines from four requestors issued in the same cycles. A reference model in the bench expects the data's line on unblock, a retry for the cancel, and the cancelled line still busy until the cancel is presented again.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } lstate_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ALLOC,
    CMD_FILL,
    CMD_CANCEL,
    CMD_EVICT
  } slot_cmd_e;

  typedef struct packed {
    logic    ok;
    lstate_e st;
  } settle_t;

  // Final stable state once writeback data lands on a busy line.
  function automatic settle_t settle_state(lstate_e base, logic vic_dirty,
                                           logic vic_shared, logic dat_shared);
    settle_t r;
    logic    sh;
    sh   = vic_shared | dat_shared;
    r.ok = 1'b1;
    r.st = base;
    unique case (base)
      ST_I, ST_E: r.st = vic_dirty ? (sh ? ST_O : ST_M) : (sh ? ST_S : ST_E);
      ST_M:       r.st = sh ? ST_O : ST_M;
      ST_S: begin
        if (sh) r.st = vic_dirty ? ST_O : ST_S;
        else    r.ok = 1'b0;
      end
      ST_O: begin
        if (sh) r.st = ST_O;
        else    r.ok = 1'b0;
      end
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wbc_line_slot.sv
module wbc_line_slot
  import wbc_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_cmd_e         cmd,
  input  logic              alloc_dirty,
  input  logic              alloc_shared,
  input  logic [ID_W-1:0]   alloc_sender,
  input  lstate_e           fill_state,
  input  logic              fill_dirty,
  input  logic [DATA_W-1:0] fill_data,
  output lstate_e           state,
  output logic              busy,
  output logic              vic_dirty,
  output logic              vic_shared,
  output logic [ID_W-1:0]   sender,
  output logic              dirty,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_I;
      busy       <= 1'b0;
      vic_dirty  <= 1'b0;
      vic_shared <= 1'b0;
      sender     <= '0;
      dirty      <= 1'b0;
      data       <= '0;
    end else begin
      unique case (cmd)
        CMD_ALLOC: begin
          busy       <= 1'b1;
          vic_dirty  <= alloc_dirty;
          vic_shared <= alloc_shared;
          sender     <= alloc_sender;
        end
        CMD_FILL: begin
          state <= fill_state;
          dirty <= dirty | fill_dirty;
          data  <= fill_data;
          busy  <= 1'b0;
        end
        CMD_CANCEL: busy <= 1'b0;
        CMD_EVICT: begin
          state <= ST_I;
          dirty <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wbc_arbiter.sv
module wbc_arbiter
  import wbc_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ID_W      = 4,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              req_valid,
  input  logic              req_cancel,
  input  logic [LINE_W-1:0] req_line,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_room,
  input  logic [LINE_W-1:0] req_victim,
  input  logic              dat_valid,
  input  logic [LINE_W-1:0] dat_line,
  input  logic              dat_shared,
  input  lstate_e           sl_state      [NUM_LINES],
  input  logic              sl_busy       [NUM_LINES],
  input  logic              sl_vdirty     [NUM_LINES],
  input  logic              sl_vshared    [NUM_LINES],
  input  logic [ID_W-1:0]   sl_sender     [NUM_LINES],
  output slot_cmd_e         sl_cmd        [NUM_LINES],
  output lstate_e           fill_state,
  output logic              fill_go,
  output logic              cancel_go,
  output logic              accept_go,
  output logic              evict_go,
  output logic              stall_go,
  output logic              err_go,
  output logic              retry_go,
  output logic              touch_go
);

  settle_t res;
  logic    vic_req;

  always_comb begin
    res       = settle_state(sl_state[dat_line], sl_vdirty[dat_line],
                             sl_vshared[dat_line], dat_shared);
    fill_go   = dat_valid && sl_busy[dat_line] && res.ok;
    err_go    = dat_valid && !fill_go;
    fill_state = res.st;

    cancel_go = req_valid && req_cancel && sl_busy[req_line] &&
                (sl_sender[req_line] == req_id) && !fill_go;
    vic_req   = req_valid && !req_cancel;
    stall_go  = vic_req && sl_busy[req_line];
    accept_go = vic_req && !stall_go && req_room;
    evict_go  = vic_req && !stall_go && !req_room && !sl_busy[req_victim];
    retry_go  = req_valid && !cancel_go && !accept_go;
    touch_go  = accept_go && (sl_state[req_line] != ST_I);
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmd
    always_comb begin
      if (fill_go && dat_line == LINE_W'(g))          sl_cmd[g] = CMD_FILL;
      else if (cancel_go && req_line == LINE_W'(g))   sl_cmd[g] = CMD_CANCEL;
      else if (accept_go && req_line == LINE_W'(g))   sl_cmd[g] = CMD_ALLOC;
      else if (evict_go && req_victim == LINE_W'(g))  sl_cmd[g] = CMD_EVICT;
      else                                            sl_cmd[g] = CMD_NONE;
    end
  end

endmodule

// File: rtl/wbc_victim_ctrl.sv
module wbc_victim_ctrl
  import wbc_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ID_W      = 4,
  parameter int DATA_W    = 32,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_cancel,
  input  logic              req_dirty,
  input  logic              req_shared,
  input  logic [LINE_W-1:0] req_line,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_room,
  input  logic [LINE_W-1:0] req_victim,
  input  logic              dat_valid,
  input  logic [LINE_W-1:0] dat_line,
  input  logic [DATA_W-1:0] dat_data,
  input  logic              dat_dirty,
  input  logic              dat_shared,
  input  logic [LINE_W-1:0] look_line,
  output logic [2:0]        look_state,
  output logic              look_busy,
  output logic              look_dirty,
  output logic [DATA_W-1:0] look_data,
  output logic              ack_valid,
  output logic [ID_W-1:0]   ack_id,
  output logic              unblock_valid,
  output logic [LINE_W-1:0] unblock_line,
  output logic              repl_valid,
  output logic [LINE_W-1:0] repl_line,
  output logic              touch_valid,
  output logic [LINE_W-1:0] touch_line,
  output logic              retry,
  output logic              proto_err
);

  lstate_e           sl_state   [NUM_LINES];
  logic              sl_busy    [NUM_LINES];
  logic              sl_vdirty  [NUM_LINES];
  logic              sl_vshared [NUM_LINES];
  logic [ID_W-1:0]   sl_sender  [NUM_LINES];
  logic              sl_dirty   [NUM_LINES];
  logic [DATA_W-1:0] sl_data    [NUM_LINES];
  slot_cmd_e         sl_cmd     [NUM_LINES];

  // Named internal events, also watched by the bound checker.
  lstate_e fill_state;
  logic    fill_go, cancel_go, accept_go, evict_go, stall_go;
  logic    err_go, retry_go, touch_go;

  wbc_arbiter #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_arb (
    .req_valid (req_valid),  .req_cancel(req_cancel), .req_line(req_line),
    .req_id    (req_id),     .req_room  (req_room),   .req_victim(req_victim),
    .dat_valid (dat_valid),  .dat_line  (dat_line),   .dat_shared(dat_shared),
    .sl_state  (sl_state),   .sl_busy   (sl_busy),    .sl_vdirty (sl_vdirty),
    .sl_vshared(sl_vshared), .sl_sender (sl_sender),  .sl_cmd    (sl_cmd),
    .fill_state(fill_state), .fill_go   (fill_go),    .cancel_go (cancel_go),
    .accept_go (accept_go),  .evict_go  (evict_go),   .stall_go  (stall_go),
    .err_go    (err_go),     .retry_go  (retry_go),   .touch_go  (touch_go)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_slot
    wbc_line_slot #(.ID_W(ID_W), .DATA_W(DATA_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd         (sl_cmd[g]),
      .alloc_dirty (req_dirty),
      .alloc_shared(req_shared),
      .alloc_sender(req_id),
      .fill_state  (fill_state),
      .fill_dirty  (dat_dirty),
      .fill_data   (dat_data),
      .state       (sl_state[g]),
      .busy        (sl_busy[g]),
      .vic_dirty   (sl_vdirty[g]),
      .vic_shared  (sl_vshared[g]),
      .sender      (sl_sender[g]),
      .dirty       (sl_dirty[g]),
      .data        (sl_data[g])
    );
  end

  assign look_state = sl_state[look_line];
  assign look_busy  = sl_busy[look_line];
  assign look_dirty = sl_dirty[look_line];
  assign look_data  = sl_data[look_line];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_valid     <= 1'b0;
      ack_id        <= '0;
      unblock_valid <= 1'b0;
      unblock_line  <= '0;
      repl_valid    <= 1'b0;
      repl_line     <= '0;
      touch_valid   <= 1'b0;
      touch_line    <= '0;
      retry         <= 1'b0;
      proto_err     <= 1'b0;
    end else begin
      ack_valid     <= accept_go;
      ack_id        <= req_id;
      unblock_valid <= fill_go || cancel_go;
      unblock_line  <= fill_go ? dat_line : req_line;
      repl_valid    <= evict_go;
      repl_line     <= req_victim;
      touch_valid   <= touch_go;
      touch_line    <= req_line;
      retry         <= retry_go;
      proto_err     <= err_go;
    end
  end

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int LINE_W = 2,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_cancel,
  input logic [ID_W-1:0]   req_id,
  input logic [LINE_W-1:0] req_victim,
  input logic              dat_valid,
  input logic [LINE_W-1:0] dat_line,
  input logic              fill_go,
  input logic              cancel_go,
  input logic              accept_go,
  input logic              evict_go,
  input logic              stall_go,
  input logic              ack_valid,
  input logic [ID_W-1:0]   ack_id,
  input logic              unblock_valid,
  input logic [LINE_W-1:0] unblock_line,
  input logic              repl_valid,
  input logic [LINE_W-1:0] repl_line,
  input logic              retry,
  input logic              proto_err
);

  a_r2_ack_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_go |=> ack_valid && ack_id == $past(req_id));

  a_r3_stall_retried: assert property (@(posedge clk) disable iff (!rst_n)
    stall_go |=> retry && !ack_valid);

  a_r4_evict_reported: assert property (@(posedge clk) disable iff (!rst_n)
    evict_go |=> repl_valid && repl_line == $past(req_victim) && retry);

  a_r7_unblock_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    unblock_valid |-> $past(fill_go || cancel_go));

  a_r10_fill_wins_unblock: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && req_valid && req_cancel) |=> unblock_line == $past(dat_line) && retry);

  a_r11_err_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(dat_valid));

endmodule

bind wbc_victim_ctrl wbc_checker #(.LINE_W(LINE_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cancel(req_cancel),
  .req_id(req_id), .req_victim(req_victim), .dat_valid(dat_valid),
  .dat_line(dat_line), .fill_go(fill_go), .cancel_go(cancel_go),
  .accept_go(accept_go), .evict_go(evict_go), .stall_go(stall_go),
  .ack_valid(ack_valid), .ack_id(ack_id), .unblock_valid(unblock_valid),
  .unblock_line(unblock_line), .repl_valid(repl_valid), .repl_line(repl_line),
  .retry(retry), .proto_err(proto_err)
);

// File: tb/wbc_victim_ctrl_tb.sv
`timescale 1ns/100ps
module wbc_victim_ctrl_tb;

  localparam int NL = 4;
  localparam int IW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 0, req_cancel = 0, req_dirty = 0, req_shared = 0;
  logic [1:0]    req_line = 0, req_victim = 0, dat_line = 0, look_line = 0;
  logic [IW-1:0] req_id = 0;
  logic          req_room = 1;
  logic          dat_valid = 0, dat_dirty = 0, dat_shared = 0;
  logic [DW-1:0] dat_data = 0;
  logic [2:0]    look_state;
  logic          look_busy, look_dirty;
  logic [DW-1:0] look_data;
  logic          ack_valid, unblock_valid, repl_valid, touch_valid, retry, proto_err;
  logic [IW-1:0] ack_id;
  logic [1:0]    unblock_line, repl_line, touch_line;

  always #5 clk = ~clk;

  wbc_victim_ctrl #(.NUM_LINES(NL), .ID_W(IW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cancel(req_cancel),
    .req_dirty(req_dirty), .req_shared(req_shared), .req_line(req_line),
    .req_id(req_id), .req_room(req_room), .req_victim(req_victim),
    .dat_valid(dat_valid), .dat_line(dat_line), .dat_data(dat_data),
    .dat_dirty(dat_dirty), .dat_shared(dat_shared), .look_line(look_line),
    .look_state(look_state), .look_busy(look_busy), .look_dirty(look_dirty),
    .look_data(look_data), .ack_valid(ack_valid), .ack_id(ack_id),
    .unblock_valid(unblock_valid), .unblock_line(unblock_line),
    .repl_valid(repl_valid), .repl_line(repl_line), .touch_valid(touch_valid),
    .touch_line(touch_line), .retry(retry), .proto_err(proto_err)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Reference model of the lines.
  int          m_st   [NL];
  bit          m_busy [NL];
  bit          m_kd   [NL];
  bit          m_ks   [NL];
  int          m_snd  [NL];
  bit          m_dirty[NL];
  logic [DW-1:0] m_data [NL];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Settling table stated in the requirements, written as a decision chain.
  function automatic int ref_final(int base, bit vd, bit vs, bit ds, output bit ok);
    bit sh;
    sh = vs || ds;
    ok = 1'b1;
    if (base == 4) return sh ? 3 : 4;
    if (base == 1 || base == 3) begin
      if (!sh) begin ok = 1'b0; return base; end
      if (base == 3) return 3;
      return vd ? 3 : 1;
    end
    if (vd) return sh ? 3 : 4;
    return sh ? 1 : 2;
  endfunction

  task automatic check_lines();
    for (int i = 0; i < NL; i++) begin
      look_line = 2'(i);
      #0.5;
      chk(look_state == 3'(m_st[i]), "R5/R6 state", look_state, m_st[i]);
      chk(look_busy == m_busy[i], "R2/R7 busy", look_busy, m_busy[i]);
      chk(look_dirty == m_dirty[i], "R7 dirty", look_dirty, m_dirty[i]);
      chk(look_data == m_data[i], "R7 data", look_data, m_data[i]);
    end
  endtask

  task automatic step(input bit rv, input bit rc, input bit rd, input bit rs,
                      input int rl, input int ri, input bit room, input int rvi,
                      input bit dv, input int dl, input logic [DW-1:0] dd,
                      input bit ddy, input bit dsh);
    bit e_err, fill, canc, vic, stall, evict, acc, touch, e_retry, ok;
    int fs;
    e_err = 0; fill = 0; fs = 0;
    if (dv) begin
      if (!m_busy[dl]) e_err = 1;
      else begin
        fs = ref_final(m_st[dl], m_kd[dl], m_ks[dl], dsh, ok);
        if (ok) fill = 1; else e_err = 1;
      end
    end
    canc    = rv && rc && m_busy[rl] && m_snd[rl] == ri && !fill;
    vic     = rv && !rc;
    stall   = vic && m_busy[rl];
    acc     = vic && !stall && room;
    evict   = vic && !stall && !room && !m_busy[rvi];
    touch   = acc && m_st[rl] != 0;
    e_retry = rv && !canc && !acc;

    @(negedge clk);
    req_valid = rv; req_cancel = rc; req_dirty = rd; req_shared = rs;
    req_line = 2'(rl); req_id = IW'(ri); req_room = room; req_victim = 2'(rvi);
    dat_valid = dv; dat_line = 2'(dl); dat_data = dd; dat_dirty = ddy; dat_shared = dsh;
    @(posedge clk);
    #1;
    req_valid = 0; dat_valid = 0;

    if (fill) begin
      m_st[dl] = fs; m_dirty[dl] = m_dirty[dl] | ddy; m_data[dl] = dd; m_busy[dl] = 0;
    end
    if (canc) m_busy[rl] = 0;
    if (acc) begin
      m_busy[rl] = 1; m_kd[rl] = rd; m_ks[rl] = rs; m_snd[rl] = ri;
    end
    if (evict) begin m_st[rvi] = 0; m_dirty[rvi] = 0; end

    chk(ack_valid == acc, "R2 ack", ack_valid, acc);
    if (acc) chk(ack_id == IW'(ri), "R2 ack_id", ack_id, ri);
    chk(retry == e_retry, "R3/R9 retry", retry, e_retry);
    chk(repl_valid == evict, "R4 repl", repl_valid, evict);
    if (evict) chk(repl_line == 2'(rvi), "R4 repl_line", repl_line, rvi);
    chk(unblock_valid == (fill || canc), "R7/R8 unblock", unblock_valid, fill || canc);
    if (fill) chk(unblock_line == 2'(dl), "R7 unblock_line", unblock_line, dl);
    else if (canc) chk(unblock_line == 2'(rl), "R8 unblock_line", unblock_line, rl);
    chk(proto_err == e_err, "R6/R11 proto_err", proto_err, e_err);
    chk(touch_valid == touch, "R12 touch", touch_valid, touch);
    if (touch) chk(touch_line == 2'(rl), "R12 touch_line", touch_line, rl);
    check_lines();
  endtask

  task automatic vic(input int l, input int id, input bit d, input bit s);
    step(1, 0, d, s, l, id, 1, 0, 0, 0, '0, 0, 0);
  endtask
  task automatic dat(input int l, input logic [DW-1:0] v, input bit d, input bit s);
    step(0, 0, 0, 0, 0, 0, 1, 0, 1, l, v, d, s);
  endtask
  task automatic cxl(input int l, input int id);
    step(1, 1, 0, 0, l, id, 1, 0, 0, 0, '0, 0, 0);
  endtask

  function automatic int look(input int l, input int what);
    return 0;
  endfunction

  bit done = 0;

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_st[i] = 0; m_busy[i] = 0; m_kd[i] = 0; m_ks[i] = 0;
      m_snd[i] = 0; m_dirty[i] = 0; m_data[i] = '0;
    end
    void'($urandom(32'h5eed_0417));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: state after reset
    chk(!ack_valid && !unblock_valid && !repl_valid && !touch_valid && !retry && !proto_err,
        "R1 outputs", 1, 0);
    check_lines();

    // R5: clean from I, plain data -> E
    vic(0, 1, 0, 0);
    dat(0, 32'hA0A0_0001, 0, 0);
    chk(m_st[0] == 2, "R5 model E", m_st[0], 2);
    // R5: dirty from I, shared data -> O
    vic(1, 2, 1, 0);
    dat(1, 32'hB1B1_0002, 1, 1);
    // R5 clean-shared from I -> S, then R6 dirty-shared from S -> O
    vic(2, 3, 0, 1);
    dat(2, 32'hC2C2_0003, 0, 0);
    vic(2, 1, 1, 1);
    dat(2, 32'hD3D3_0004, 1, 0);
    // R6: undefined from O (clean, nothing shared) -> error, held busy
    vic(2, 1, 0, 0);
    dat(2, 32'hE4E4_0005, 0, 0);
    chk(proto_err == 1 && look_busy == 0, "R6 error raised", proto_err, 1);
    look_line = 2'd2; #0.5;
    chk(look_busy == 1 && look_state == 3'd3, "R6 held busy in O", look_state, 3);
    dat(2, 32'hE4E4_0006, 0, 1);
    // R3: stall on busy line
    vic(3, 1, 1, 0);
    vic(3, 2, 0, 0);
    chk(retry == 1 && ack_valid == 0, "R3 stall", retry, 1);
    // R9: cancel from wrong sender
    cxl(3, 2);
    chk(retry == 1 && unblock_valid == 0, "R9 wrong sender", unblock_valid, 0);
    // R8: matching cancel from base I
    cxl(3, 1);
    chk(unblock_valid == 1 && unblock_line == 2'd3, "R8 cancel unblock", unblock_line, 3);
    look_line = 2'd3; #0.5;
    chk(look_state == 3'd0 && look_busy == 0, "R8 back to I", look_state, 0);
    // R9: cancel to an idle line
    cxl(3, 1);
    chk(retry == 1, "R9 idle cancel", retry, 1);
    // R12 hit on E, then R8 cancel restores E
    vic(0, 1, 1, 0);
    chk(touch_valid == 1 && touch_line == 2'd0, "R12 touch on hit", touch_line, 0);
    cxl(0, 1);
    look_line = 2'd0; #0.5;
    chk(look_state == 3'd2, "R8 back to E", look_state, 2);
    // R4: no room, victim line 1 not busy -> evicted
    step(1, 0, 1, 0, 3, 0, 0, 1, 0, 0, '0, 0, 0);
    chk(repl_valid == 1 && repl_line == 2'd1 && retry == 1, "R4 evict", repl_line, 1);
    // R4: victim busy -> deferred
    vic(2, 3, 0, 1);
    step(1, 0, 1, 0, 3, 0, 0, 2, 0, 0, '0, 0, 0);
    chk(repl_valid == 0 && retry == 1, "R4 defer", repl_valid, 0);
    // R10: data for line 2 and cancel for line 0 in the same cycle
    vic(0, 2, 0, 0);
    step(1, 1, 0, 0, 0, 2, 1, 0, 1, 2, 32'h5A5A_0007, 0, 1);
    chk(unblock_line == 2'd2 && retry == 1, "R10 data wins", unblock_line, 2);
    cxl(0, 2);
    chk(unblock_line == 2'd0, "R10 cancel later", unblock_line, 0);
    // R11: data to idle line
    dat(3, 32'hFFFF_0008, 1, 0);
    chk(proto_err == 1 && unblock_valid == 0, "R11 idle data", proto_err, 1);

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      bit rv, rc, dv;
      rv = ($urandom % 4) != 0;
      rc = ($urandom % 4) == 0;
      dv = ($urandom % 2) == 0;
      step(rv, rc, 1'($urandom), 1'($urandom), int'($urandom % NL), int'($urandom % 4),
           ($urandom % 5) != 0, int'($urandom % NL),
           dv, int'($urandom % NL), $urandom, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule